// File: doc/BRIEF.md
# Three-Source Interrupt Controller

This block decides when a small microcontroller core is interrupted. There are three sources. The first is an external pin, which is edge sensitive and whose polarity software selects. The second is a timer event, raised by either a carry or a capture pulse. The third is a software trap, raised when the core executes opcode zero. The two maskable sources each latch a pending flag. That flag reaches the core only when its own enable and the global enable are both set. The software trap ignores all masking.

Software reaches the block through one 8-bit control/status register. The pending flags stay set until software writes them clear, and software reads them to decide which source to service first. When the core acknowledges an interrupt, the hardware clears the global enable, so that the handler is not interrupted again before software re-enables. The external pin passes through a two-flop synchroniser before its edges are detected.

Top module: `intc3_top`

## Requirements
- R1: After reset the register reads 0x00 and `irqReq` is low. A write loads bits 0 to 5 from `regWrData`. The layout is: bit0 global enable, bit1 external enable, bit2 timer enable, bit3 external edge select, bit4 external pending, bit5 timer pending, bit6 software pending (read-only), bit7 reads 0.
- R2: `irqReq` is high if the software pending bit is set. It is also high if the global enable is set and at least one source has both its enable bit and its pending bit set.
- R3: The external edge select chooses the edge that sets the external pending bit: 0 for rising, 1 for falling. The opposite edge has no effect, and a level that does not change sets nothing. The pending bit is set three clock edges after the pin changes.
- R4: A cycle with `irqAck` high clears the global enable. This takes priority over a write in the same cycle.
- R5: A timer carry or timer capture pulse sets the timer pending bit on the next edge, even when the timer or global enable is clear.
- R6: Pending bits hold until software writes them to 0.
- R7: A `swTrap` pulse sets the software pending bit, which raises `irqReq` whatever the enables hold. An acknowledge clears it, unless a new trap arrives in the same cycle.
- R8: An event that occurs in the same cycle as a software write clearing its pending bit leaves that bit set.
- R9: Writes to bits 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extPin | input | 1 | Asynchronous external interrupt pin |
| timerCarry | input | 1 | One-cycle timer carry pulse |
| timerCapture | input | 1 | One-cycle timer capture pulse |
| swTrap | input | 1 | One-cycle pulse: opcode zero executed |
| regWr | input | 1 | Write strobe for the control/status register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Current register contents |
| irqReq | output | 1 | Interrupt request to the core |
| irqAck | input | 1 | Interrupt acknowledge from the core |

## Verification
The pin is driven through rising and falling transitions under each edge select. This separates the selected edge from the ignored one, and shows that a steady level never sets the pending bit. Timer pulses from both triggers arrive with the enables set and with them clear. This tells pending capture apart from request gating. Same-cycle collisions are driven on purpose: an event against a clearing write, an acknowledge against a write that sets the global enable, and a trap against an acknowledge. These show which side wins each race.

// File: rtl/intc3_pkg.sv
package intc3_pkg;
  localparam int REG_W = 8;
  localparam int B_GIE  = 0;
  localparam int B_XEN  = 1;
  localparam int B_TEN  = 2;
  localparam int B_XFAL = 3;
  localparam int B_XPND = 4;
  localparam int B_TPND = 5;
  localparam int B_SPND = 6;

  typedef struct packed {
    logic extEdge;
    logic tmrHit;
    logic swHit;
    logic regWr;
    logic ack;
  } intcStrobes_t;
endpackage

// File: rtl/intc3_ctrl.sv
module intc3_ctrl
  import intc3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         extPin,
  input  logic         extFall,
  input  logic         timerCarry,
  input  logic         timerCapture,
  input  logic         swTrap,
  input  logic         regWr,
  input  logic         irqAck,
  output intcStrobes_t strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;
  logic          prevQ;
  logic          syncOut;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[LAST-1:0], extPin};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= extPin;
      end
    end
  endgenerate

  assign syncOut = syncChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncOut;
  end

  always_comb begin
    strobes.extEdge = extFall ? (prevQ & ~syncOut) : (~prevQ & syncOut);
    strobes.tmrHit  = timerCarry | timerCapture;
    strobes.swHit   = swTrap;
    strobes.regWr   = regWr;
    strobes.ack     = irqAck;
  end
endmodule

// File: rtl/intc3_dp.sv
module intc3_dp
  import intc3_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  intcStrobes_t     strobes,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             extFall,
  output logic             irq
);
  logic gie, xEn, tEn, xFal, xPnd, tPnd, sPnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gie  <= 1'b0;
      xEn  <= 1'b0;
      tEn  <= 1'b0;
      xFal <= 1'b0;
      xPnd <= 1'b0;
      tPnd <= 1'b0;
      sPnd <= 1'b0;
    end else begin
      if (strobes.regWr) begin
        gie  <= wrData[B_GIE];
        xEn  <= wrData[B_XEN];
        tEn  <= wrData[B_TEN];
        xFal <= wrData[B_XFAL];
        xPnd <= wrData[B_XPND] | strobes.extEdge;
        tPnd <= wrData[B_TPND] | strobes.tmrHit;
      end else begin
        xPnd <= xPnd | strobes.extEdge;
        tPnd <= tPnd | strobes.tmrHit;
      end
      if (strobes.ack) gie <= 1'b0;
      if (strobes.swHit)    sPnd <= 1'b1;
      else if (strobes.ack) sPnd <= 1'b0;
    end
  end

  always_comb begin
    rdData         = '0;
    rdData[B_GIE]  = gie;
    rdData[B_XEN]  = xEn;
    rdData[B_TEN]  = tEn;
    rdData[B_XFAL] = xFal;
    rdData[B_XPND] = xPnd;
    rdData[B_TPND] = tPnd;
    rdData[B_SPND] = sPnd;
  end

  assign extFall = xFal;
  assign irq = sPnd | (gie & ((xEn & xPnd) | (tEn & tPnd)));

  AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ack |=> !gie); // R4
  AST_SW_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    sPnd |-> irq); // R7
  AST_SW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (sPnd && !strobes.ack) |=> sPnd); // R7
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (sPnd || gie)); // R2
  AST_XPND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (xPnd && !strobes.regWr) |=> xPnd); // R6
  AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tmrHit |=> tPnd); // R8
endmodule

// File: rtl/intc3_top.sv
module intc3_top
  import intc3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPin,
  input  logic             timerCarry,
  input  logic             timerCapture,
  input  logic             swTrap,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irqReq,
  input  logic             irqAck
);
  intcStrobes_t strobes;
  logic         extFall;

  intc3_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .extFall(extFall),
    .timerCarry(timerCarry), .timerCapture(timerCapture), .swTrap(swTrap),
    .regWr(regWr), .irqAck(irqAck), .strobes(strobes)
  );

  intc3_dp i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .rdData(regRdData), .extFall(extFall), .irq(irqReq)
  );
endmodule

// File: tb/test_intc3_top.sv
module test_intc3_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPin = 1'b0, timerCarry = 1'b0, timerCapture = 1'b0, swTrap = 1'b0;
  logic regWr = 1'b0, irqAck = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic irqReq;

  typedef struct { logic [7:0] rdv; logic irq; string tag; } expItem_t;
  expItem_t expQ[$];
  event sampleEv;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  intc3_top i_intc3_top (
    .clk(clk), .rstN(rstN), .extPin(extPin), .timerCarry(timerCarry),
    .timerCapture(timerCapture), .swTrap(swTrap), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .irqReq(irqReq),
    .irqAck(irqAck)
  );

  // Monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        nRun++;
        if (regRdData !== it.rdv || irqReq !== it.irq) begin
          nFail++;
          $display("FAIL %s: reg=%02h irq=%0b expected reg=%02h irq=%0b",
                   it.tag, regRdData, irqReq, it.rdv, it.irq);
        end
      end
    end
  end

  task automatic expect_state(input logic [7:0] v, input logic i, input string tag);
    expItem_t it;
    it.rdv = v; it.irq = i; it.tag = tag;
    expQ.push_back(it);
    ->sampleEv;
    #0;
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk); regWrData = v; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic setPin(input logic v);
    @(negedge clk); extPin = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: reg=%02h irq=%0b expected completion", regRdData, irqReq);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expect_state(8'h00, 1'b0, "R1 reset");
    wrReg(8'h03);
    expect_state(8'h03, 1'b0, "R1 write");
    setPin(1'b1);
    expect_state(8'h13, 1'b1, "R3 rising edge / R2 request");
    pulseAck();
    expect_state(8'h12, 1'b0, "R4 ack clears global enable");
    // masked timer capture
    @(negedge clk); timerCapture = 1'b1;
    @(negedge clk); timerCapture = 1'b0;
    expect_state(8'h32, 1'b0, "R5 capture sets pending while masked");
    wrReg(8'h06);
    expect_state(8'h06, 1'b0, "R6 software clear");
    @(negedge clk); timerCarry = 1'b1;
    @(negedge clk); timerCarry = 1'b0;
    expect_state(8'h26, 1'b0, "R2 gated by global enable");
    wrReg(8'h27);
    expect_state(8'h27, 1'b1, "R2 timer request");
    repeat (3) @(negedge clk);
    expect_state(8'h27, 1'b1, "R6 pending holds");
    wrReg(8'h07);
    expect_state(8'h07, 1'b0, "R6 clear timer pending");
    // falling edge select
    wrReg(8'h0B);
    repeat (4) @(negedge clk);
    expect_state(8'h0B, 1'b0, "R3 steady level no edge");
    setPin(1'b0);
    expect_state(8'h1B, 1'b1, "R3 falling edge");
    wrReg(8'h0B);
    setPin(1'b1);
    expect_state(8'h0B, 1'b0, "R3 rising ignored with falling select");
    // software trap
    wrReg(8'h00);
    @(negedge clk); swTrap = 1'b1;
    @(negedge clk); swTrap = 1'b0;
    expect_state(8'h40, 1'b1, "R7 trap unmasked");
    pulseAck();
    expect_state(8'h00, 1'b0, "R7 ack clears trap");
    wrReg(8'hC0);
    expect_state(8'h00, 1'b0, "R9 bits 6 and 7 ignored");
    // event against clearing write
    @(negedge clk); regWrData = 8'h00; regWr = 1'b1; timerCarry = 1'b1;
    @(negedge clk); regWr = 1'b0; timerCarry = 1'b0;
    expect_state(8'h20, 1'b0, "R8 event wins over clear");
    // ack against write setting global enable
    @(negedge clk); regWrData = 8'h25; regWr = 1'b1; irqAck = 1'b1;
    @(negedge clk); regWr = 1'b0; irqAck = 1'b0;
    expect_state(8'h24, 1'b0, "R4 ack wins over write");
    // trap against ack
    @(negedge clk); swTrap = 1'b1; irqAck = 1'b1;
    @(negedge clk); swTrap = 1'b0; irqAck = 1'b0;
    expect_state(8'h64, 1'b1, "R7 new trap survives ack");
    pulseAck();
    expect_state(8'h24, 1'b0, "R7 ack clears after trap");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule